// File: doc/BRIEF.md
# Soft-Start Boot Sequencer

This block drives the start-up of a core voltage regulator. It stays idle while its enable input is low. Once enable is seen high, it moves a 7-bit target code upward one code at a time, starting from the lowest-voltage code. Each move waits a fixed number of clock cycles, so the output voltage ramps linearly. When the target reaches the programmed boot code, the block holds it there for a fixed time. It then asserts an active-low clock-enable output. After a further long delay it raises power-good.

From the moment clock-enable is asserted, the target code passes the external VID inputs straight through. The processor can then step the voltage up or down one LSB at a time. Before that moment the VID inputs have no effect. The step period, the boot hold and the power-good delay are parameters in clock cycles, so a bench can shorten them. Code value 0 is the lowest voltage and larger values are higher voltages.

Top module: `boot_sequencer`

## Requirements
- R1: While reset is held, and in the idle state, targetCode is 0, clkEnN is 1, powerGood is 0 and stIdle is the only status output that is high.
- R2: At the first clock edge that samples enable high in idle, the block enters the ramp state (stRamp high) with targetCode 0.
- R3: During the ramp, targetCode rises by exactly 1 every STEP_CYCLES cycles, so it equals k exactly k*STEP_CYCLES edges after ramp entry. It never skips a code and never exceeds bootCode.
- R4: One edge after targetCode reaches bootCode, the block enters the boot hold (stBootHold high) and keeps targetCode equal to bootCode for HOLD_CYCLES edges.
- R5: In the idle, ramp and boot-hold states, vidIn has no effect on targetCode.
- R6: clkEnN falls at the edge that ends the boot hold and stays 0 in the wait and run states.
- R7: powerGood rises exactly PG_CYCLES edges after clkEnN falls, together with stRun, and is 0 in every other state.
- R8: While clkEnN is 0, targetCode equals vidIn in the same cycle, including single-LSB steps up and down.
- R9: An edge that samples enable low returns the block to idle from any state. This overrides a ramp step or a timer expiry due at that same edge.
- R10: With bootCode equal to 0, no step is taken and the boot hold begins one edge after ramp entry.
- R11: Exactly one of stIdle, stRamp, stBootHold, stWaitPg, stRun is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start request; low returns to idle |
| bootCode | input | 7 | Boot target code, held stable during start-up |
| vidIn | input | 7 | External target code used after start-up |
| targetCode | output | 7 | Active target code |
| clkEnN | output | 1 | Active-low clock-enable |
| powerGood | output | 1 | High once start-up has completed |
| stIdle | output | 1 | Idle state status |
| stRamp | output | 1 | Ramp state status |
| stBootHold | output | 1 | Boot hold status |
| stWaitPg | output | 1 | Waiting for power-good status |
| stRun | output | 1 | Run state status |

## Verification
Two events can fall on the same clock edge: enable being sampled low, and either a scheduled ramp step or the expiry of the boot-hold timer. The bench provokes this by dropping enable so that it is sampled exactly at the third ramp edge, and in a second case exactly at the edge that would end the hold. In both cases the next cycle must show idle with targetCode 0 and clkEnN high, rather than code 1 or the wait state. A restart after each abort must again begin from code 0.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RAMP,
    SEQ_HOLD,
    SEQ_WAITPG,
    SEQ_RUN
  } seqState_t;

  typedef struct packed {
    logic clearRamp;
    logic stepRamp;
    logic selVid;
  } pathCtl_t;

  function automatic int maxOf3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/boot_seq_path.sv
module boot_seq_path
  import boot_seq_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [CODE_W-1:0] bootCode,
  input  logic [CODE_W-1:0] vidIn,
  output logic              rampAtBoot,
  output logic [CODE_W-1:0] targetCode
);

  logic [CODE_W-1:0] rampCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCode <= '0;
    end else if (ctl.clearRamp) begin
      rampCode <= '0;
    end else if (ctl.stepRamp) begin
      rampCode <= rampCode + 1'b1;
    end
  end

  always_comb begin
    rampAtBoot = (rampCode >= bootCode);
    targetCode = ctl.selVid ? vidIn : rampCode;
  end

  // ramp code only moves by a single step upward or back to zero
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rampCode) |-> (rampCode == $past(rampCode) + 1'b1 || rampCode == '0));

  // ramp code is never advanced beyond the boot code
  assert_no_overshoot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.stepRamp) |-> rampCode <= bootCode);

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int STEP_CYCLES = 250,
  parameter int HOLD_CYCLES = 9000,
  parameter int PG_CYCLES   = 900000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     rampAtBoot,
  output pathCtl_t ctl,
  output logic     clkEnN,
  output logic     powerGood,
  output logic     stIdle,
  output logic     stRamp,
  output logic     stBootHold,
  output logic     stWaitPg,
  output logic     stRun
);

  localparam int TMAX  = maxOf3(STEP_CYCLES, HOLD_CYCLES, PG_CYCLES);
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [TW-1:0] STEP_END = TW'(STEP_CYCLES - 1);
  localparam logic [TW-1:0] HOLD_END = TW'(HOLD_CYCLES - 1);
  localparam logic [TW-1:0] PG_END   = TW'(PG_CYCLES - 1);

  seqState_t state, stateNxt;
  logic [TW-1:0] timer, timerNxt;

  always_comb begin
    stateNxt      = state;
    timerNxt      = timer + 1'b1;
    ctl.clearRamp = 1'b0;
    ctl.stepRamp  = 1'b0;
    ctl.selVid    = (state == SEQ_WAITPG) || (state == SEQ_RUN);
    unique case (state)
      SEQ_IDLE: begin
        ctl.clearRamp = 1'b1;
        timerNxt      = '0;
        if (enable) stateNxt = SEQ_RAMP;
      end
      SEQ_RAMP: begin
        if (rampAtBoot) begin
          stateNxt = SEQ_HOLD;
          timerNxt = '0;
        end else if (timer == STEP_END) begin
          ctl.stepRamp = 1'b1;
          timerNxt     = '0;
        end
      end
      SEQ_HOLD: begin
        if (timer == HOLD_END) begin
          stateNxt = SEQ_WAITPG;
          timerNxt = '0;
        end
      end
      SEQ_WAITPG: begin
        if (timer == PG_END) begin
          stateNxt = SEQ_RUN;
          timerNxt = '0;
        end
      end
      SEQ_RUN: timerNxt = '0;
      default: stateNxt = SEQ_IDLE;
    endcase
    if (!enable) begin
      stateNxt      = SEQ_IDLE;
      timerNxt      = '0;
      ctl.clearRamp = 1'b1;
      ctl.stepRamp  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      timer <= '0;
    end else begin
      state <= stateNxt;
      timer <= timerNxt;
    end
  end

  always_comb begin
    stIdle     = (state == SEQ_IDLE);
    stRamp     = (state == SEQ_RAMP);
    stBootHold = (state == SEQ_HOLD);
    stWaitPg   = (state == SEQ_WAITPG);
    stRun      = (state == SEQ_RUN);
    clkEnN     = !(stWaitPg || stRun);
    powerGood  = stRun;
  end

  assert_status_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stIdle, stRamp, stBootHold, stWaitPg, stRun}) == 1);

  assert_disable_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> stIdle && clkEnN && !powerGood);

  assert_clken_after_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEnN) |-> $past(stBootHold));

  assert_pg_after_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> $past(stWaitPg) && !clkEnN);

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int STEP_CYCLES = 250,
  parameter int HOLD_CYCLES = 9000,
  parameter int PG_CYCLES   = 900000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] bootCode,
  input  logic [CODE_W-1:0] vidIn,
  output logic [CODE_W-1:0] targetCode,
  output logic              clkEnN,
  output logic              powerGood,
  output logic              stIdle,
  output logic              stRamp,
  output logic              stBootHold,
  output logic              stWaitPg,
  output logic              stRun
);

  pathCtl_t ctl;
  logic     rampAtBoot;

  boot_seq_ctrl #(
    .STEP_CYCLES(STEP_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES),
    .PG_CYCLES  (PG_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .rampAtBoot(rampAtBoot),
    .ctl       (ctl),
    .clkEnN    (clkEnN),
    .powerGood (powerGood),
    .stIdle    (stIdle),
    .stRamp    (stRamp),
    .stBootHold(stBootHold),
    .stWaitPg  (stWaitPg),
    .stRun     (stRun)
  );

  boot_seq_path #(
    .CODE_W(CODE_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .bootCode  (bootCode),
    .vidIn     (vidIn),
    .rampAtBoot(rampAtBoot),
    .targetCode(targetCode)
  );

  // before clock-enable, the target never reflects a code above the boot code
  assert_vid_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |-> targetCode <= bootCode);

endmodule

// File: tb/boot_sequencer_bench.sv
`timescale 1ns/1ps
module boot_sequencer_bench;

  localparam int STEP = 3;
  localparam int HOLD = 5;
  localparam int PG   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [6:0] bootCode = 7'd5;
  logic [6:0] vidIn = 7'h55;
  logic [6:0] targetCode;
  logic clkEnN, powerGood, stIdle, stRamp, stBootHold, stWaitPg, stRun;

  int nChecks = 0;
  int nFails  = 0;
  int now     = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_sequencer #(
    .CODE_W(7), .STEP_CYCLES(STEP), .HOLD_CYCLES(HOLD), .PG_CYCLES(PG)
  ) u_boot_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .bootCode(bootCode), .vidIn(vidIn),
    .targetCode(targetCode), .clkEnN(clkEnN), .powerGood(powerGood),
    .stIdle(stIdle), .stRamp(stRamp), .stBootHold(stBootHold),
    .stWaitPg(stWaitPg), .stRun(stRun)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // advance to 1 ns after edge number t counted from ramp entry (edge 0)
  task automatic goTo(input int t);
    while (now < t) begin
      @(posedge clk);
      #1;
      now++;
    end
  endtask

  task automatic startSeq(input logic [6:0] code);
    bootCode = code;
    enable   = 1'b1;
    @(posedge clk);
    #1;
    now = 0;
  endtask

  task automatic stopSeq();
    enable = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 idle after disable", stIdle, 1);
    chk("R9 code cleared", targetCode, 0);
    chk("R9 clkEnN released", clkEnN, 1);
    chk("R9 powerGood low", powerGood, 0);
  endtask

  task automatic testReset();
    chk("R1 reset code", targetCode, 0);
    chk("R1 reset clkEnN", clkEnN, 1);
    chk("R1 reset powerGood", powerGood, 0);
    chk("R1 reset status", {stIdle, stRamp, stBootHold, stWaitPg, stRun}, 5'b10000);
  endtask

  task automatic testNormalBoot();
    vidIn = 7'h55;
    startSeq(7'd5);
    chk("R2 ramp entry", stRamp, 1);
    chk("R2 ramp starts at 0", targetCode, 0);
    goTo(2);
    chk("R3 no early step", targetCode, 0);
    goTo(3);
    chk("R3 first step", targetCode, 1);
    goTo(14);
    chk("R3 code 4", targetCode, 4);
    goTo(15);
    chk("R3 reaches boot", targetCode, 5);
    chk("R3 still ramp", stRamp, 1);
    goTo(16);
    chk("R4 hold entry", stBootHold, 1);
    chk("R5 vid ignored in hold", targetCode, 5);
    chk("R6 clkEnN high in hold", clkEnN, 1);
    goTo(20);
    chk("R4 hold kept", stBootHold, 1);
    goTo(21);
    chk("R6 clkEnN asserted", clkEnN, 0);
    chk("R11 wait state", {stIdle, stRamp, stBootHold, stWaitPg, stRun}, 5'b00010);
    chk("R8 vid passes", targetCode, 7'h55);
    goTo(28);
    chk("R7 no early powerGood", powerGood, 0);
    goTo(29);
    chk("R7 powerGood", powerGood, 1);
    chk("R7 run state", stRun, 1);
    vidIn = 7'h56;
    #1;
    chk("R8 step up", targetCode, 7'h56);
    vidIn = 7'h55;
    #1;
    chk("R8 step down", targetCode, 7'h55);
    goTo(40);
    chk("R7 powerGood stays", powerGood, 1);
    stopSeq();
  endtask

  task automatic testVidIgnoredRamp();
    vidIn = 7'h7F;
    startSeq(7'd4);
    goTo(4);
    chk("R5 vid ignored in ramp", targetCode, 1);
    vidIn = 7'h00;
    goTo(6);
    chk("R5 vid ignored still", targetCode, 2);
    stopSeq();
  endtask

  task automatic testAbortOnStep();
    startSeq(7'd5);
    goTo(2);
    enable = 1'b0;          // sampled at edge 3, the first step edge
    goTo(3);
    chk("R9 abort beats step", targetCode, 0);
    chk("R9 abort beats step state", stIdle, 1);
  endtask

  task automatic testAbortOnHoldEnd();
    startSeq(7'd2);
    goTo(7);
    chk("R4 hold with code 2", stBootHold, 1);
    goTo(11);
    enable = 1'b0;          // sampled at edge 12, the hold expiry edge
    goTo(12);
    chk("R9 abort beats expiry", stIdle, 1);
    chk("R9 clkEnN stays high", clkEnN, 1);
    startSeq(7'd2);
    chk("R2 restart from zero", targetCode, 0);
    stopSeq();
  endtask

  task automatic testZeroBoot();
    startSeq(7'd0);
    chk("R10 ramp entry", stRamp, 1);
    goTo(1);
    chk("R10 immediate hold", stBootHold, 1);
    chk("R10 code zero", targetCode, 0);
    goTo(6);
    chk("R10 wait after hold", stWaitPg, 1);
    goTo(14);
    chk("R10 run", powerGood, 1);
    stopSeq();
  endtask

  task automatic testMaxBoot();
    vidIn = 7'h10;
    startSeq(7'd127);
    goTo(380);
    chk("R3 code 126", targetCode, 126);
    goTo(381);
    chk("R3 top code", targetCode, 127);
    goTo(382);
    chk("R4 hold at top", stBootHold, 1);
    chk("R3 no wrap", targetCode, 127);
    goTo(387);
    chk("R6 clkEnN at top", clkEnN, 0);
    goTo(395);
    chk("R7 powerGood at top", powerGood, 1);
    stopSeq();
  endtask

  initial begin
    #1;
    testReset();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormalBoot();
    testVidIgnoredRamp();
    testAbortOnStep();
    testAbortOnHoldEnd();
    testZeroBoot();
    testMaxBoot();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule